// File: doc/BRIEF.md
# Branch Target and Condition Unit

This unit resolves control transfers for a 32-bit RISC core whose fetch path works on aligned 32-bit words. Each cycle it receives the current instruction address, the sequential next address, a branch operation code, a raw displacement field, two register operands and the condition flag. From these it decides whether the transfer happens and where it goes. It also produces the return address for call forms and a write-enable for the link register.

Relative targets are always based on the instruction address with its two low bits cleared. The displacement is sign-extended from the width that the operation implies, then scaled by four. Register-indirect jumps use the register value with its low two bits cleared. All results are registered, so they appear one clock after the inputs are presented.

Top module: `brc_next_pc`

## Requirements
- R1: The flag branches depend on `cbit_i`. Codes 5 and 6 are taken only when `cbit_i` is 1. Codes 7 and 8 are taken only when `cbit_i` is 0.
- R2: The displacement is sign-extended from a width chosen by the code. Short forms (codes 1, 3, 5, 7) use `disp_i[7:0]`. Long forms (codes 2, 4, 6, 8) use `disp_i[23:0]`. Register-compare forms (codes 9 to 16) use `disp_i[15:0]`. The extended value is multiplied by 4 and added to the base address.
- R3: The base for every relative target is `pc_i` with bits [1:0] forced to zero, whatever those two bits are.
- R4: Code 9 is taken when `ra_i` equals `rb_i`. Code 10 is taken when they differ.
- R5: Codes 11 to 16 test `ra_i` alone, with `ra_i` treated as a signed value. The tests are: 11 equals zero, 12 not zero, 13 at least zero, 14 above zero, 15 at most zero, 16 below zero.
- R6: Codes 17 (jump) and 18 (jump with link) are always taken. Their target is `ra_i` with bits [1:0] cleared.
- R7: `link_o` equals `pc_i` with bits [1:0] cleared, plus 4.
- R8: `link_en_o` is 1 only for code 3, code 4 (branch with link) and code 18. These forms are always taken.
- R9: For code 0, codes 19 to 31, and any branch whose condition fails, `taken_o` is 0 and `target_o` equals `seq_pc_i`.
- R10: Outputs are registered: they reflect the inputs present at the previous rising edge. A synchronous reset clears `taken_o`, `link_en_o`, `target_o` and `link_o` to 0.
- R11: Codes 1 and 2 (plain branch) are always taken, and never assert `link_en_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pc_i | input | 32 | Address of the branch instruction |
| seq_pc_i | input | 32 | Sequential next address |
| op_i | input | 5 | Operation code (see requirements) |
| disp_i | input | 24 | Raw displacement field |
| ra_i | input | 32 | First register operand |
| rb_i | input | 32 | Second register operand |
| cbit_i | input | 1 | Condition flag |
| taken_o | output | 1 | Transfer taken |
| target_o | output | 32 | Next fetch address |
| link_en_o | output | 1 | Link register write enable |
| link_o | output | 32 | Return address |

## Verification
The bench builds the unit with its default parameters: a 32-bit data path, 8/16/24-bit displacement fields and a 2-bit word alignment. These values let it reach sign-bit boundaries of each displacement width, as well as the most-negative register value in the signed zero tests. It also covers address wrap-around when a negative displacement is added, and instruction addresses whose low bits are non-zero, so that the alignment rule is tested.

// File: rtl/brc_pkg.sv
package brc_pkg;
  typedef enum logic [4:0] {
    OP_NONE  = 5'd0,  OP_BRA_S = 5'd1,  OP_BRA_L = 5'd2,
    OP_BL_S  = 5'd3,  OP_BL_L  = 5'd4,  OP_BC_S  = 5'd5,
    OP_BC_L  = 5'd6,  OP_BNC_S = 5'd7,  OP_BNC_L = 5'd8,
    OP_BEQ   = 5'd9,  OP_BNE   = 5'd10, OP_BEQZ  = 5'd11,
    OP_BNEZ  = 5'd12, OP_BGEZ  = 5'd13, OP_BGTZ  = 5'd14,
    OP_BLEZ  = 5'd15, OP_BLTZ  = 5'd16, OP_JMP   = 5'd17,
    OP_JL    = 5'd18
  } brop_e;

  typedef enum logic [1:0] {
    DW_NONE  = 2'd0,
    DW_SHORT = 2'd1,
    DW_MID   = 2'd2,
    DW_LONG  = 2'd3
  } dsel_e;
endpackage

// File: rtl/brc_cond.sv
module brc_cond
  import brc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  brop_e             op,
  input  logic [XLEN-1:0]   ra,
  input  logic [XLEN-1:0]   rb,
  input  logic              cbit,
  output logic              taken,
  output logic              is_call,
  output logic              is_jump,
  output dsel_e             dsel
);
  logic ra_zero, ra_neg;
  assign ra_zero = (ra == '0);
  assign ra_neg  = ra[XLEN-1];

  always_comb begin
    taken   = 1'b0;
    is_call = 1'b0;
    is_jump = 1'b0;
    dsel    = DW_NONE;
    unique case (op)
      OP_BRA_S: begin taken = 1'b1; dsel = DW_SHORT; end
      OP_BRA_L: begin taken = 1'b1; dsel = DW_LONG;  end
      OP_BL_S:  begin taken = 1'b1; is_call = 1'b1; dsel = DW_SHORT; end
      OP_BL_L:  begin taken = 1'b1; is_call = 1'b1; dsel = DW_LONG;  end
      OP_BC_S:  begin taken = cbit;  dsel = DW_SHORT; end
      OP_BC_L:  begin taken = cbit;  dsel = DW_LONG;  end
      OP_BNC_S: begin taken = !cbit; dsel = DW_SHORT; end
      OP_BNC_L: begin taken = !cbit; dsel = DW_LONG;  end
      OP_BEQ:   begin taken = (ra == rb); dsel = DW_MID; end
      OP_BNE:   begin taken = (ra != rb); dsel = DW_MID; end
      OP_BEQZ:  begin taken = ra_zero;            dsel = DW_MID; end
      OP_BNEZ:  begin taken = !ra_zero;           dsel = DW_MID; end
      OP_BGEZ:  begin taken = !ra_neg;            dsel = DW_MID; end
      OP_BGTZ:  begin taken = !ra_neg && !ra_zero; dsel = DW_MID; end
      OP_BLEZ:  begin taken = ra_neg || ra_zero;  dsel = DW_MID; end
      OP_BLTZ:  begin taken = ra_neg;             dsel = DW_MID; end
      OP_JMP:   begin taken = 1'b1; is_jump = 1'b1; end
      OP_JL:    begin taken = 1'b1; is_jump = 1'b1; is_call = 1'b1; end
      default:  begin taken = 1'b0; end
    endcase
  end
endmodule

// File: rtl/brc_target.sv
module brc_target
  import brc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int DISP_W  = 24,
  parameter int SHORT_W = 8,
  parameter int MID_W   = 16,
  parameter int ALIGN   = 2
) (
  input  logic [XLEN-1:0]   pc,
  input  logic [XLEN-1:0]   seq_pc,
  input  logic [XLEN-1:0]   ra,
  input  logic [DISP_W-1:0] disp,
  input  dsel_e             dsel,
  input  logic              is_jump,
  input  logic              taken,
  output logic [XLEN-1:0]   target,
  output logic [XLEN-1:0]   link
);
  localparam logic [XLEN-1:0] LOW_MASK  = XLEN'((1 << ALIGN) - 1);
  localparam logic [XLEN-1:0] WORD_STEP = XLEN'(1 << ALIGN);

  logic [XLEN-1:0] base, jump_tgt, ext, offs;

  assign base     = pc & ~LOW_MASK;
  assign jump_tgt = ra & ~LOW_MASK;
  assign link     = base + WORD_STEP;

  always_comb begin
    unique case (dsel)
      DW_SHORT: ext = XLEN'($signed(disp[SHORT_W-1:0]));
      DW_MID:   ext = XLEN'($signed(disp[MID_W-1:0]));
      DW_LONG:  ext = XLEN'($signed(disp));
      default:  ext = '0;
    endcase
  end

  assign offs = ext << ALIGN;

  always_comb begin
    if (!taken)       target = seq_pc;
    else if (is_jump) target = jump_tgt;
    else              target = base + offs;
  end
endmodule

// File: rtl/brc_next_pc.sv
module brc_next_pc
  import brc_pkg::*;
#(
  parameter int XLEN    = 32,
  parameter int DISP_W  = 24,
  parameter int SHORT_W = 8,
  parameter int MID_W   = 16,
  parameter int ALIGN   = 2,
  parameter int OP_W    = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [XLEN-1:0]   pc_i,
  input  logic [XLEN-1:0]   seq_pc_i,
  input  logic [OP_W-1:0]   op_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [XLEN-1:0]   ra_i,
  input  logic [XLEN-1:0]   rb_i,
  input  logic              cbit_i,
  output logic              taken_o,
  output logic [XLEN-1:0]   target_o,
  output logic              link_en_o,
  output logic [XLEN-1:0]   link_o
);
  brop_e           op;
  dsel_e           dsel;
  logic            taken_c, call_c, jump_c;
  logic [XLEN-1:0] target_c, link_c;

  assign op = brop_e'(op_i);

  brc_cond #(.XLEN(XLEN)) u_cond (
    .op(op), .ra(ra_i), .rb(rb_i), .cbit(cbit_i),
    .taken(taken_c), .is_call(call_c), .is_jump(jump_c), .dsel(dsel)
  );

  brc_target #(
    .XLEN(XLEN), .DISP_W(DISP_W), .SHORT_W(SHORT_W),
    .MID_W(MID_W), .ALIGN(ALIGN)
  ) u_tgt (
    .pc(pc_i), .seq_pc(seq_pc_i), .ra(ra_i), .disp(disp_i),
    .dsel(dsel), .is_jump(jump_c), .taken(taken_c),
    .target(target_c), .link(link_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      taken_o   <= 1'b0;
      target_o  <= '0;
      link_en_o <= 1'b0;
      link_o    <= '0;
    end else begin
      taken_o   <= taken_c;
      target_o  <= target_c;
      link_en_o <= call_c && taken_c;
      link_o    <= link_c;
    end
  end
endmodule

// File: rtl/brc_next_pc_chk.sv
module brc_next_pc_chk
  import brc_pkg::*;
#(
  parameter int XLEN   = 32,
  parameter int DISP_W = 24,
  parameter int ALIGN  = 2,
  parameter int OP_W   = 5
) (
  input logic              clk,
  input logic              rst,
  input logic [XLEN-1:0]   pc_i,
  input logic [XLEN-1:0]   seq_pc_i,
  input logic [OP_W-1:0]   op_i,
  input logic [DISP_W-1:0] disp_i,
  input logic [XLEN-1:0]   ra_i,
  input logic [XLEN-1:0]   rb_i,
  input logic              cbit_i,
  input logic              taken_o,
  input logic [XLEN-1:0]   target_o,
  input logic              link_en_o,
  input logic [XLEN-1:0]   link_o
);
  localparam logic [XLEN-1:0] LOW_MASK = XLEN'((1 << ALIGN) - 1);
  logic armed;
  always_ff @(posedge clk) armed <= !rst;

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!taken_o && !link_en_o && target_o == '0)); // R10

  AST_LINK_NEEDS_TAKEN: assert property (@(posedge clk) disable iff (rst)
    link_en_o |-> taken_o); // R8

  AST_NOT_TAKEN_SEQ: assert property (@(posedge clk) disable iff (rst || !armed)
    !taken_o |-> (target_o == $past(seq_pc_i))); // R9

  AST_LINK_VALUE: assert property (@(posedge clk) disable iff (rst || !armed)
    link_en_o |-> (link_o == ($past(pc_i) & ~LOW_MASK) + XLEN'(4))); // R7

  AST_CALL_ENABLES_LINK: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(op_i) == OP_W'(OP_BL_S) || $past(op_i) == OP_W'(OP_JL)) |-> link_en_o); // R8

  AST_FLAG_BRANCH: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(op_i) == OP_W'(OP_BC_L)) |-> (taken_o == $past(cbit_i))); // R1

  AST_JUMP_ALIGNED: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(op_i) == OP_W'(OP_JMP)) |-> (taken_o && target_o == ($past(ra_i) & ~LOW_MASK))); // R6
endmodule

bind brc_next_pc brc_next_pc_chk #(
  .XLEN(XLEN), .DISP_W(DISP_W), .ALIGN(ALIGN), .OP_W(OP_W)
) u_chk (
  .clk(clk), .rst(rst), .pc_i(pc_i), .seq_pc_i(seq_pc_i), .op_i(op_i),
  .disp_i(disp_i), .ra_i(ra_i), .rb_i(rb_i), .cbit_i(cbit_i),
  .taken_o(taken_o), .target_o(target_o), .link_en_o(link_en_o), .link_o(link_o)
);

// File: tb/brc_next_pc_tb.sv
module brc_next_pc_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] pc_i = '0, seq_pc_i = '0, ra_i = '0, rb_i = '0;
  logic [4:0]  op_i = '0;
  logic [23:0] disp_i = '0;
  logic        cbit_i = 1'b0;
  logic        taken_o, link_en_o;
  logic [31:0] target_o, link_o;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  brc_next_pc u_dut (
    .clk(clk), .rst(rst), .pc_i(pc_i), .seq_pc_i(seq_pc_i), .op_i(op_i),
    .disp_i(disp_i), .ra_i(ra_i), .rb_i(rb_i), .cbit_i(cbit_i),
    .taken_o(taken_o), .target_o(target_o), .link_en_o(link_en_o), .link_o(link_o)
  );

  function automatic logic [31:0] al(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction
  function automatic logic [31:0] rel(input logic [31:0] pc, input int w, input logic [23:0] d);
    logic [31:0] e;
    if (w == 8)       e = {{24{d[7]}}, d[7:0]};
    else if (w == 16) e = {{16{d[15]}}, d[15:0]};
    else              e = {{8{d[23]}}, d};
    return al(pc) + {e[29:0], 2'b00};
  endfunction

  task automatic check(input string req, input logic et, input logic [31:0] etg,
                       input logic el, input logic [31:0] elk);
    checks++;
    if (taken_o !== et || target_o !== etg || link_en_o !== el || link_o !== elk) begin
      fails++;
      $display("FAIL %s: got taken=%0b target=%h link_en=%0b link=%h, expected taken=%0b target=%h link_en=%0b link=%h",
               req, taken_o, target_o, link_en_o, link_o, et, etg, el, elk);
    end
  endtask

  task automatic apply(input logic [4:0] op, input logic [31:0] pc, input logic [31:0] seq,
                       input logic [23:0] d, input logic [31:0] a, input logic [31:0] b,
                       input logic c);
    @(negedge clk);
    op_i = op; pc_i = pc; seq_pc_i = seq; disp_i = d; ra_i = a; rb_i = b; cbit_i = c;
    @(negedge clk);
  endtask

  task automatic t_reset;
    // R10: registered outputs cleared by reset
    check("R10 reset", 1'b0, 32'h0, 1'b0, 32'h0);
  endtask

  task automatic t_none;
    apply(5'd0, 32'h0000_1002, 32'h0000_1004, 24'h0000_05, 32'h1, 32'h1, 1'b1);
    check("R9 no-op", 1'b0, 32'h0000_1004, 1'b0, 32'h0000_1004);
    apply(5'd25, 32'h0000_2000, 32'h0000_2002, 24'h00_0010, 32'h0, 32'h0, 1'b1);
    check("R9 unused code", 1'b0, 32'h0000_2002, 1'b0, 32'h0000_2004);
  endtask

  task automatic t_bra;
    apply(5'd1, 32'h0000_1006, 32'h0000_1008, 24'h0000_FE, 32'h0, 32'h0, 1'b0);
    check("R11 R2 R3 short neg", 1'b1, rel(32'h0000_1006, 8, 24'hFE), 1'b0, 32'h0000_1008);
    apply(5'd2, 32'h0040_0000, 32'h0040_0004, 24'h7F_FFFF, 32'h0, 32'h0, 1'b0);
    check("R11 R2 long pos", 1'b1, rel(32'h0040_0000, 24, 24'h7FFFFF), 1'b0, 32'h0040_0004);
    apply(5'd2, 32'h0000_0010, 32'h0000_0014, 24'h80_0000, 32'h0, 32'h0, 1'b0);
    check("R2 long wrap", 1'b1, 32'hFE00_0010, 1'b0, 32'h0000_0014);
  endtask

  task automatic t_flag;
    apply(5'd5, 32'h0000_3000, 32'h0000_3002, 24'h0000_40, 32'h0, 32'h0, 1'b1);
    check("R1 bc taken", 1'b1, 32'h0000_3100, 1'b0, 32'h0000_3004);
    apply(5'd6, 32'h0000_3000, 32'h0000_3004, 24'h00_0040, 32'h0, 32'h0, 1'b0);
    check("R1 bc not taken", 1'b0, 32'h0000_3004, 1'b0, 32'h0000_3004);
    apply(5'd7, 32'h0000_3000, 32'h0000_3002, 24'h0000_80, 32'h0, 32'h0, 1'b0);
    check("R1 bnc taken", 1'b1, 32'h0000_2E00, 1'b0, 32'h0000_3004);
    apply(5'd8, 32'h0000_3000, 32'h0000_3004, 24'h00_0001, 32'h0, 32'h0, 1'b1);
    check("R1 bnc not taken", 1'b0, 32'h0000_3004, 1'b0, 32'h0000_3004);
  endtask

  task automatic t_regcmp;
    apply(5'd9, 32'h0000_5000, 32'h0000_5004, 24'hAB_8000, 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1'b0);
    check("R4 beq equal mid", 1'b1, rel(32'h0000_5000, 16, 24'h8000), 1'b0, 32'h0000_5004);
    apply(5'd9, 32'h0000_5000, 32'h0000_5004, 24'h00_0010, 32'h1, 32'h2, 1'b0);
    check("R4 beq differ", 1'b0, 32'h0000_5004, 1'b0, 32'h0000_5004);
    apply(5'd10, 32'h0000_5000, 32'h0000_5004, 24'h00_0010, 32'h1, 32'h2, 1'b0);
    check("R4 bne differ", 1'b1, 32'h0000_5040, 1'b0, 32'h0000_5004);
  endtask

  task automatic t_zero;
    apply(5'd13, 32'h100, 32'h104, 24'h10, 32'h8000_0000, 32'h0, 1'b0);
    check("R5 bgez min", 1'b0, 32'h104, 1'b0, 32'h104);
    apply(5'd16, 32'h100, 32'h104, 24'h10, 32'h8000_0000, 32'h0, 1'b0);
    check("R5 bltz min", 1'b1, 32'h140, 1'b0, 32'h104);
    apply(5'd14, 32'h100, 32'h104, 24'h10, 32'h0, 32'h0, 1'b0);
    check("R5 bgtz zero", 1'b0, 32'h104, 1'b0, 32'h104);
    apply(5'd15, 32'h100, 32'h104, 24'h10, 32'h0, 32'h0, 1'b0);
    check("R5 blez zero", 1'b1, 32'h140, 1'b0, 32'h104);
    apply(5'd14, 32'h100, 32'h104, 24'h10, 32'h7FFF_FFFF, 32'h0, 1'b0);
    check("R5 bgtz max", 1'b1, 32'h140, 1'b0, 32'h104);
    apply(5'd11, 32'h100, 32'h104, 24'h10, 32'h1, 32'h0, 1'b0);
    check("R5 beqz nonzero", 1'b0, 32'h104, 1'b0, 32'h104);
    apply(5'd12, 32'h100, 32'h104, 24'h10, 32'h1, 32'h0, 1'b0);
    check("R5 bnez nonzero", 1'b1, 32'h140, 1'b0, 32'h104);
  endtask

  task automatic t_calls;
    apply(5'd3, 32'h0000_1002, 32'h0000_1004, 24'h0000_02, 32'h0, 32'h0, 1'b0);
    check("R7 R8 bl short odd slot", 1'b1, 32'h0000_1008, 1'b1, 32'h0000_1004);
    apply(5'd4, 32'h0001_0000, 32'h0001_0004, 24'hFF_FFFF, 32'h0, 32'h0, 1'b0);
    check("R8 bl long", 1'b1, 32'h0000_FFFC, 1'b1, 32'h0001_0004);
    apply(5'd17, 32'h0000_2002, 32'h0000_2004, 24'h0, 32'h1234_567B, 32'h0, 1'b0);
    check("R6 jump", 1'b1, 32'h1234_5678, 1'b0, 32'h0000_2004);
    apply(5'd18, 32'h0000_2002, 32'h0000_2004, 24'h0, 32'h8765_4322, 32'h0, 1'b0);
    check("R6 R7 R8 jump link", 1'b1, 32'h8765_4320, 1'b1, 32'h0000_2004);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_none();
    t_bra();
    t_flag();
    t_regcmp();
    t_zero();
    t_calls();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule